// File: doc/BRIEF.md
# Dual-Bank Q-Channel Subcode Buffer

This block keeps two ten-byte banks of Q-channel subcode data. At any time one bank, the serving bank, is read byte by byte by the output side through an index port. The other bank is free for a host processor, which loads or inspects it through three byte-wide registers: a configuration register, a start register and a data port. The host first writes the start register to pick a bank and rewind the byte pointer. It then moves a whole bank through the data port, one byte per access.

A 3-bit frame counter moves at every subcode sync. On a sync where the counter is zero, the counter reloads from a programmable value. If swapping is enabled, the two banks also trade roles on that sync. Separately, a self-clearing one-shot request makes the output side read the other bank for exactly one frame. The serving bank then returns to the original, and the bank roles themselves do not change. The output side receives a one-cycle frame-start pulse after each sync, and the serving bank for the new frame is already valid in that cycle.

Top module: `qsub_bank_buffer`

## Requirements
- R1: After a synchronous reset, the configuration register reads 0x00, `out_bank` is 0, `frame_start` is 0 and every byte of both banks reads 0.
- R2: Host register select codes are 0 for configuration, 1 for start and 2 for data; code 3 and the start register read 0. In the configuration register, bit 7 is the swap enable, bit 6 is the one-shot request or busy flag, bits 5:3 are the reload value and bits 2:0 are the frame counter. A configuration write stores bit 7 and bits 5:3, and a read returns all four fields.
- R3: Bits 2:0 of a configuration write are ignored. The frame counter only changes on a sync.
- R4: On each `frame_sync`, the counter loads the reload value if it is zero and otherwise decrements by one. Between syncs it holds.
- R5: With the swap enable at 0, the bank roles never change.
- R6: With the swap enable at 1, the bank roles swap on a sync that finds the counter at zero, and at no other time.
- R7: Writing 1 to bit 6 while no one-shot is active arms it. The next sync makes the output side read the non-serving bank for one frame, and the sync after that restores it. Bit 6 reads 1 from the arming write until that second sync and reads 0 afterwards. Writing 0 to bit 6 has no effect.
- R8: During a one-shot insertion, the host's notion of the current bank stays the original bank.
- R9: A start write with bit 7 = 1 selects the current bank for host access, and bit 7 = 0 selects the other bank. The write rewinds the byte pointer to 0. The choice is latched and does not follow a later swap.
- R10: Each data-port read or write transfers one byte at the pointer and advances the pointer, which wraps from 9 to 0.
- R11: `out_data` shows the serving bank's byte at `out_idx`, and reads 0 for an index above 9. `out_bank` names the serving bank.
- R12: `frame_start` is high for exactly the one cycle after each cycle in which `frame_sync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| frame_sync | input | 1 | Subcode sync pulse from the modulator |
| out_idx | input | 4 | Byte index requested by the output side |
| out_data | output | 8 | Byte of the serving bank at `out_idx` |
| out_bank | output | 1 | Number of the bank now serving the output |
| frame_start | output | 1 | One-cycle pulse marking the start of a frame |

## Verification
A wrong frame counter shows on the counter field of the configuration readback in the cycle after the faulty sync. It also shows as a swap on the wrong frame, and `out_bank` and `out_data` reveal that at the following `frame_start`. A corrupted host pointer or latched bank selection shows as wrong bytes on the very next data-port read. A stuck one-shot state appears as an `out_bank` that fails to return, or as a bit 6 that never clears, within two syncs. The bench therefore compares every output against a behavioural model on every cycle, with the host and sync traffic mixed at random, so a divergence is caught in the cycle it reaches a port.

// File: rtl/qsub_pkg.sv
package qsub_pkg;

    localparam int QS_DATA_W = 8;
    localparam int QS_BYTES  = 10;
    localparam int QS_CNT_W  = 3;
    localparam int QS_PTR_W  = $clog2(QS_BYTES);
    localparam int QS_SEL_W  = 2;
    localparam int QS_NBANK  = 2;

    // bit of the start register that chooses current (1) or other (0) bank
    localparam int START_CUR_BIT = QS_DATA_W - 1;

    typedef enum logic [QS_SEL_W-1:0] {
        SEL_CFG   = 2'd0,
        SEL_START = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OS_IDLE   = 2'd0,
        OS_ARMED  = 2'd1,
        OS_INSERT = 2'd2
    } oneshot_e;

    // configuration register image, MSB first
    typedef struct packed {
        logic                sw_en;
        logic                os_busy;
        logic [QS_CNT_W-1:0] reload;
        logic [QS_CNT_W-1:0] count;
    } cfg_view_t;

    typedef struct packed {
        logic                 we;
        logic                 bank;
        logic [QS_PTR_W-1:0]  ptr;
        logic [QS_DATA_W-1:0] data;
    } mem_wr_t;

    function automatic logic [QS_PTR_W-1:0] ptr_advance(input logic [QS_PTR_W-1:0] p);
        logic [QS_PTR_W-1:0] last;
        last = QS_PTR_W'(QS_BYTES - 1);
        return (p >= last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/qsub_bank_mem.sv
module qsub_bank_mem
    import qsub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  mem_wr_t              wr,
    input  logic                 host_bank,
    input  logic [QS_PTR_W-1:0]  host_ptr,
    output logic [QS_DATA_W-1:0] host_q,
    input  logic                 out_bank,
    input  logic [QS_PTR_W-1:0]  out_idx,
    output logic [QS_DATA_W-1:0] out_q
);

    localparam int NPORT = 2;

    logic [QS_DATA_W-1:0] bank_q [QS_NBANK][QS_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < QS_NBANK; b++) begin
                for (int i = 0; i < QS_BYTES; i++) begin
                    bank_q[b][i] <= '0;
                end
            end
        end else if (wr.we && (32'(wr.ptr) < QS_BYTES)) begin
            bank_q[wr.bank][wr.ptr] <= wr.data;
        end
    end

    // two identical read ports: port 0 host side, port 1 output side
    for (genvar p = 0; p < NPORT; p++) begin : g_rport
        logic                 sel_bank;
        logic [QS_PTR_W-1:0]  sel_idx;
        logic [QS_DATA_W-1:0] q;

        assign sel_bank = (p == 0) ? host_bank : out_bank;
        assign sel_idx  = (p == 0) ? host_ptr  : out_idx;

        always_comb begin
            q = '0;
            if (32'(sel_idx) < QS_BYTES) begin
                q = bank_q[sel_bank][sel_idx];
            end
        end
    end

    assign host_q = g_rport[0].q;
    assign out_q  = g_rport[1].q;

endmodule

// File: rtl/qsub_frame_ctrl.sv
module qsub_frame_ctrl
    import qsub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync,
    input  logic                 cfg_we,
    input  logic [QS_DATA_W-1:0] cfg_wdata,
    output cfg_view_t            cfg_view,
    output logic                 base_bank,
    output logic                 serve_bank,
    output logic                 frame_start
);

    logic                sw_en_q;
    logic [QS_CNT_W-1:0] reload_q;
    logic [QS_CNT_W-1:0] count_q;
    logic                base_q;
    logic                fs_q;
    oneshot_e            os_q;
    oneshot_e            os_d;
    cfg_view_t           wr_view;
    logic                cnt_zero;
    logic                swap_now;

    assign wr_view  = cfg_view_t'(cfg_wdata);
    assign cnt_zero = (count_q == '0);
    assign swap_now = sync && sw_en_q && cnt_zero;

    always_comb begin
        os_d = os_q;
        if (sync) begin
            case (os_q)
                OS_ARMED:  os_d = OS_INSERT;
                OS_INSERT: os_d = OS_IDLE;
                default:   os_d = os_q;
            endcase
        end else if (cfg_we && wr_view.os_busy && (os_q == OS_IDLE)) begin
            os_d = OS_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en_q  <= 1'b0;
            reload_q <= '0;
            count_q  <= '0;
            base_q   <= 1'b0;
            fs_q     <= 1'b0;
            os_q     <= OS_IDLE;
        end else begin
            if (cfg_we) begin
                sw_en_q  <= wr_view.sw_en;
                reload_q <= wr_view.reload;
            end
            if (sync) begin
                count_q <= cnt_zero ? reload_q : count_q - 1'b1;
            end
            if (swap_now) begin
                base_q <= ~base_q;
            end
            os_q <= os_d;
            fs_q <= sync;
        end
    end

    assign cfg_view = '{
        sw_en:   sw_en_q,
        os_busy: (os_q != OS_IDLE),
        reload:  reload_q,
        count:   count_q
    };

    assign base_bank   = base_q;
    assign serve_bank  = base_q ^ (os_q == OS_INSERT);
    assign frame_start = fs_q;

endmodule

// File: rtl/qsub_host_port.sv
module qsub_host_port
    import qsub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [QS_SEL_W-1:0]  addr,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [QS_DATA_W-1:0] wdata,
    input  logic                 base_bank,
    input  cfg_view_t            cfg_view,
    input  logic [QS_DATA_W-1:0] mem_q,
    output logic                 cfg_we,
    output logic [QS_DATA_W-1:0] cfg_wdata,
    output mem_wr_t              mem_wr,
    output logic                 acc_bank,
    output logic [QS_PTR_W-1:0]  acc_ptr,
    output logic [QS_DATA_W-1:0] rdata
);

    reg_sel_e            sel;
    logic                start_we;
    logic                data_hit;
    logic                acc_bank_q;
    logic [QS_PTR_W-1:0] ptr_q;

    assign sel      = reg_sel_e'(addr);
    assign start_we = wr && (sel == SEL_START);
    assign data_hit = (wr || rd) && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_bank_q <= 1'b0;
            ptr_q      <= '0;
        end else if (start_we) begin
            acc_bank_q <= wdata[START_CUR_BIT] ? base_bank : ~base_bank;
            ptr_q      <= '0;
        end else if (data_hit) begin
            ptr_q <= ptr_advance(ptr_q);
        end
    end

    assign cfg_we    = wr && (sel == SEL_CFG);
    assign cfg_wdata = wdata;

    assign mem_wr = '{
        we:   wr && (sel == SEL_DATA),
        bank: acc_bank_q,
        ptr:  ptr_q,
        data: wdata
    };

    always_comb begin
        case (sel)
            SEL_CFG:  rdata = cfg_view;
            SEL_DATA: rdata = mem_q;
            default:  rdata = '0;
        endcase
    end

    assign acc_bank = acc_bank_q;
    assign acc_ptr  = ptr_q;

endmodule

// File: rtl/qsub_bank_buffer.sv
module qsub_bank_buffer
    import qsub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [QS_SEL_W-1:0]  host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [QS_DATA_W-1:0] host_wdata,
    output logic [QS_DATA_W-1:0] host_rdata,
    input  logic                 frame_sync,
    input  logic [QS_PTR_W-1:0]  out_idx,
    output logic [QS_DATA_W-1:0] out_data,
    output logic                 out_bank,
    output logic                 frame_start
);

    cfg_view_t            cfg_view;
    logic                 base_bank;
    logic                 serve_bank;
    logic                 cfg_we;
    logic [QS_DATA_W-1:0] cfg_wdata;
    mem_wr_t              mem_wr;
    logic                 acc_bank;
    logic [QS_PTR_W-1:0]  acc_ptr;
    logic [QS_DATA_W-1:0] mem_host_q;

    qsub_frame_ctrl u_frame (
        .clk         (clk),
        .rst         (rst),
        .sync        (frame_sync),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_view    (cfg_view),
        .base_bank   (base_bank),
        .serve_bank  (serve_bank),
        .frame_start (frame_start)
    );

    qsub_host_port u_host (
        .clk       (clk),
        .rst       (rst),
        .addr      (host_addr),
        .wr        (host_wr),
        .rd        (host_rd),
        .wdata     (host_wdata),
        .base_bank (base_bank),
        .cfg_view  (cfg_view),
        .mem_q     (mem_host_q),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mem_wr    (mem_wr),
        .acc_bank  (acc_bank),
        .acc_ptr   (acc_ptr),
        .rdata     (host_rdata)
    );

    qsub_bank_mem u_mem (
        .clk       (clk),
        .rst       (rst),
        .wr        (mem_wr),
        .host_bank (acc_bank),
        .host_ptr  (acc_ptr),
        .host_q    (mem_host_q),
        .out_bank  (serve_bank),
        .out_idx   (out_idx),
        .out_q     (out_data)
    );

    assign out_bank = serve_bank;

endmodule

// File: rtl/qsub_bank_buffer_chk.sv
module qsub_bank_buffer_chk
    import qsub_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_sync,
    input logic                frame_start,
    input logic                base_bank,
    input logic                serve_bank,
    input cfg_view_t           cfg_view,
    input logic [QS_PTR_W-1:0] acc_ptr,
    input logic                host_wr,
    input logic [QS_SEL_W-1:0] host_addr
);

    p_pulse_after_sync_r12: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> frame_start);

    p_pulse_only_after_sync_r12: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> !frame_start);

    p_hold_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !cfg_view.sw_en) |=> $stable(base_bank));

    p_swap_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && cfg_view.sw_en && (cfg_view.count == '0)) |=> (base_bank != $past(base_bank)));

    p_no_swap_between_syncs_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> $stable(base_bank));

    p_cnt_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && (cfg_view.count == '0)) |=> (cfg_view.count == $past(cfg_view.reload)));

    p_cnt_down_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && (cfg_view.count != '0)) |=> (cfg_view.count == QS_CNT_W'($past(cfg_view.count) - 1'b1)));

    p_cnt_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && (host_addr == QS_SEL_W'(0)) && !frame_sync) |=> $stable(cfg_view.count));

    p_insert_one_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && (serve_bank != base_bank)) |=> (serve_bank == base_bank));

    always @(posedge clk) begin
        if (!rst) begin
            p_ptr_in_range_r10: assert (32'(acc_ptr) < QS_BYTES);
        end
    end

endmodule

bind qsub_bank_buffer qsub_bank_buffer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_sync  (frame_sync),
    .frame_start (frame_start),
    .base_bank   (base_bank),
    .serve_bank  (serve_bank),
    .cfg_view    (cfg_view),
    .acc_ptr     (acc_ptr),
    .host_wr     (host_wr),
    .host_addr   (host_addr)
);

// File: tb/test_qsub_bank_buffer.sv
module test_qsub_bank_buffer;
    import qsub_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       frame_sync = 1'b0;
    logic [3:0] out_idx = '0;
    logic [7:0] out_data;
    logic       out_bank;
    logic       frame_start;

    always #4 clk = ~clk;

    qsub_bank_buffer i_qsub_bank_buffer (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frame_sync(frame_sync), .out_idx(out_idx), .out_data(out_data),
        .out_bank(out_bank), .frame_start(frame_start)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_mem [2][QS_BYTES];
    int m_base, m_os, m_cnt, m_rel, m_en, m_acc, m_ptr, m_fs;

    always @(posedge clk) begin
        int o_base, o_os, o_cnt, o_rel, o_en;
        if (rst) begin
            foreach (m_mem[b, i]) m_mem[b][i] = 0;
            m_base = 0; m_os = 0; m_cnt = 0; m_rel = 0; m_en = 0;
            m_acc = 0; m_ptr = 0; m_fs = 0;
        end else begin
            o_base = m_base; o_os = m_os; o_cnt = m_cnt; o_rel = m_rel; o_en = m_en;
            if (host_wr && host_addr == 2'd1) begin
                m_acc = host_wdata[7] ? o_base : 1 - o_base;
                m_ptr = 0;
            end else if ((host_wr || host_rd) && host_addr == 2'd2) begin
                if (host_wr) m_mem[m_acc][m_ptr] = int'(host_wdata);
                m_ptr = (m_ptr == QS_BYTES - 1) ? 0 : m_ptr + 1;
            end
            if (host_wr && host_addr == 2'd0) begin
                m_en  = int'(host_wdata[7]);
                m_rel = int'(host_wdata[5:3]);
                if (host_wdata[6] && o_os == 0 && !frame_sync) m_os = 1;
            end
            if (frame_sync) begin
                if (o_en == 1 && o_cnt == 0) m_base = 1 - o_base;
                m_cnt = (o_cnt == 0) ? o_rel : o_cnt - 1;
                if (o_os == 1) m_os = 2;
                else if (o_os == 2) m_os = 0;
            end
            m_fs = int'(frame_sync);
        end
    end

    function automatic int exp_rdata();
        case (host_addr)
            2'd0: return m_en * 128 + ((m_os != 0) ? 64 : 0) + m_rel * 8 + m_cnt;
            2'd2: return m_mem[m_acc][m_ptr];
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison, sampled 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            int eb;
            eb = m_base ^ ((m_os == 2) ? 1 : 0);
            check("R11 out_bank", 32'(out_bank), 32'(eb));
            check("R11 out_data", 32'(out_data), (out_idx < QS_BYTES) ? 32'(m_mem[eb][out_idx]) : 32'd0);
            check("R12 frame_start", 32'(frame_start), 32'(m_fs));
            check((host_addr == 2'd0) ? "R2 cfg readback" : "R10 host read",
                  32'(host_rdata), 32'(exp_rdata()));
        end
    end

    task automatic cyc(input logic [1:0] a = 2'd0, input logic w = 1'b0, input logic r = 1'b0,
                       input logic [7:0] d = 8'h00, input logic s = 1'b0);
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_wdata = d; frame_sync = s;
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input int exp);
        cyc(a);
        #1;
        check(tag, 32'(host_rdata), 32'(exp));
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        out_idx = 4'd3;
        // R1 reset state
        peek(2'd0, "R1 cfg after reset", 0);
        check("R1 out_bank after reset", 32'(out_bank), 0);
        check("R1 frame_start after reset", 32'(frame_start), 0);
        check("R1 bank byte after reset", 32'(out_data), 0);

        // fill other bank (bank 1), twelve writes to exercise the wrap
        cyc(2'd1, 1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 12; i++) cyc(2'd2, 1'b1, 1'b0, 8'h10 + 8'(i));
        // fill current bank (bank 0)
        cyc(2'd1, 1'b1, 1'b0, 8'h80);
        for (int i = 0; i < 10; i++) cyc(2'd2, 1'b1, 1'b0, 8'hA0 + 8'(i));

        // R10 readback with wrap
        cyc(2'd1, 1'b1, 1'b0, 8'h00);
        peek(2'd2, "R10 wrapped write landed on byte 0", 8'h1A);
        cyc(2'd2, 1'b0, 1'b1);
        peek(2'd2, "R10 byte 1 after one read", 8'h1B);
        for (int i = 0; i < 9; i++) cyc(2'd2, 1'b0, 1'b1);
        peek(2'd2, "R10 pointer wraps after byte 9", 8'h1A);

        // R11 output sweep
        for (int i = 0; i < 16; i++) begin
            cyc();
            out_idx = 4'(i);
        end
        out_idx = 4'd12;
        #1 check("R11 index above 9 reads zero", 32'(out_data), 0);
        out_idx = 4'd4;
        #1 check("R11 serving bank byte 4", 32'(out_data), 8'hA4);

        // R3 counter field read-only
        cyc(2'd0, 1'b1, 1'b0, 8'h07);
        peek(2'd0, "R3 count bits ignore writes", 8'h00);

        // R4 and R5: reload 2, swapping off
        cyc(2'd0, 1'b1, 1'b0, 8'h10);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        peek(2'd0, "R4 reload at zero", 8'h12);
        check("R12 pulse after sync", 32'(frame_start), 1);
        cyc();
        #1 check("R12 pulse lasts one cycle", 32'(frame_start), 0);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        peek(2'd0, "R4 decrement", 8'h11);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        peek(2'd0, "R4 second reload", 8'h12);
        check("R5 no swap while disabled", 32'(out_bank), 0);

        // R6: enable swapping, count is 2
        cyc(2'd0, 1'b1, 1'b0, 8'h90);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        cyc();
        #1 check("R6 no swap while counting", 32'(out_bank), 0);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        cyc();
        #1 check("R6 swap at zero count", 32'(out_bank), 1);

        // R9 bank selection (current bank is now bank 1)
        cyc(2'd1, 1'b1, 1'b0, 8'h80);
        peek(2'd2, "R9 bit7=1 selects current bank", 8'h1A);
        cyc(2'd1, 1'b1, 1'b0, 8'h00);
        peek(2'd2, "R9 bit7=0 selects other bank", 8'hA0);
        for (int i = 0; i < 3; i++) cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        peek(2'd2, "R9 selection latched across swap", 8'hA0);
        check("R6 swapped back after reload", 32'(out_bank), 0);

        // R7 / R8 one-shot, swapping off, reload 0, count 2
        cyc(2'd0, 1'b1, 1'b0, 8'h00);
        cyc(2'd0, 1'b1, 1'b0, 8'h40);
        peek(2'd0, "R7 one-shot pending", 8'h42);
        cyc(2'd0, 1'b1, 1'b0, 8'h00);
        peek(2'd0, "R7 writing 0 does not cancel", 8'h42);
        check("R7 no insertion before sync", 32'(out_bank), 0);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        out_idx = 4'd0;
        peek(2'd0, "R7 busy during insertion", 8'h41);
        check("R7 other bank inserted", 32'(out_bank), 1);
        check("R7 inserted bank data", 32'(out_data), 8'h1A);
        cyc(2'd1, 1'b1, 1'b0, 8'h80);
        peek(2'd2, "R8 host current bank stays original", 8'hA0);
        cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
        peek(2'd0, "R7 one-shot self-clears", 8'h00);
        check("R7 back to original bank", 32'(out_bank), 0);

        // mixed traffic against the model
        for (int k = 0; k < 2000; k++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: cyc();
                1: cyc(2'd0, 1'b1, 1'b0, 8'($urandom));
                2: cyc(2'd1, 1'b1, 1'b0, 8'($urandom));
                3: cyc(2'd2, 1'b1, 1'b0, 8'($urandom));
                4: cyc(2'd2, 1'b0, 1'b1);
                default: cyc(2'($urandom % 4), 1'b0, 1'b0, 8'h00, 1'b1);
            endcase
            out_idx = 4'($urandom);
        end
        cyc();
        cyc();
        finish_run();
    end

endmodule